// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits on the read path of a memory that times its own internal write cycles. While the write engine reports a cycle in progress, reads do not return array contents. They return a status word. Bit 7 carries the inverse of bit 7 of the byte most recently written. Bit 6 changes value on each new read access. All other bits read as a fixed fill value. Once the engine drops its busy flag, reads return true array data, and bit 6 no longer moves.

Host software can end its wait in either of two ways. It can poll until bit 7 matches the value it wrote, or it can read twice in a row and wait until bit 6 is the same on both reads. A write attempt that the engine rejects still raises busy for a full cycle time, so reads during that time are status reads. The pad drivers are modelled as a data word plus an enable. The data word is zero whenever the enable is low. All outputs are registered: the word seen after a clock edge reflects the inputs sampled at that edge.

Top module: `wr_status_responder`

## Requirements
- R1: While reset is asserted and on the first edge after its release with idle strobes, `dout` is 0 and `dout_en` is 0.
- R2: After the edge that samples `ce_n`=0, `oe_n`=0 and `we_n`=1, `dout_en` is 1. For every other combination of these three inputs it is 0, including when `we_n` is 0.
- R3: Whenever `dout_en` is 0, `dout` is 0. This models the high-impedance pads.
- R4: A read sampled while `busy`=1 returns bit 7 equal to the inverse of bit 7 of `last_byte`.
- R5: During `busy`, the internal toggle state inverts once at the start of each read access. A read starts when the combined strobe goes active after being inactive. Bit 6 of a status read shows the state after that inversion, and it stays constant while one read access is held over many cycles.
- R6: During `busy`, bits 5 to 0 of a read return 0.
- R7: A read sampled while `busy`=0 returns `array_data` unchanged on all 8 bits, and bit 6 does not toggle.
- R8: The toggle state is cleared to 0 on each 0-to-1 change of `busy`. The first read of every write cycle therefore returns bit 6 = 1, whatever the previous cycle left behind.
- R9: During `busy`, `array_data` has no effect on the output. A rejected write that raises `busy` gives the same status reads as an accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | Internal write cycle in progress, from the write engine |
| last_byte | input | 8 | Most recently written data byte |
| array_data | input | 8 | Data read from the array at the current address |
| dout | output | 8 | Read data toward the pads |
| dout_en | output | 1 | Pad output enable |

## Verification
The hardest situation to reach is a stale toggle state at the start of a new write cycle. The previous cycle must end with the toggle state at 1, busy must fall and then rise again, and the next read must still show 1. The bench reaches this by counting its status reads so that an odd number of accesses ends each cycle. It then opens a new cycle with idle strobes before reading. Held reads spanning several cycles show that bit 6 moves only on strobe starts and not on clock edges. A sweep of all 256 last-byte values, each paired with inverted array data, confirms that the polling bit and the fill bits never depend on the array.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

    // Registered control state of the responder.
    typedef struct packed {
        logic rd;    // combined read strobe, previous cycle
        logic busy;  // busy flag, previous cycle
        logic tog;   // toggle state reported on the toggle bit
        logic en;    // registered pad enable
    } ctl_t;

    localparam ctl_t CTL_RESET = '{rd: 1'b0, busy: 1'b0, tog: 1'b0, en: 1'b0};

endpackage

// File: rtl/wsr_strobe_decode.sv
module wsr_strobe_decode (
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic rd_prev,
    output logic rd,
    output logic rd_start
);
    // A read access needs both enables low and no write strobe.
    assign rd       = !ce_n && !oe_n && we_n;
    assign rd_start = rd && !rd_prev;
endmodule

// File: rtl/wsr_toggle_next.sv
module wsr_toggle_next (
    input  logic tog_q,
    input  logic busy,
    input  logic busy_prev,
    input  logic rd_start,
    output logic tog_next
);
    logic base;

    always_comb begin
        // A new write cycle restarts the sequence from zero.
        base     = (busy && !busy_prev) ? 1'b0 : tog_q;
        tog_next = (busy && rd_start) ? ~base : base;
    end
endmodule

// File: rtl/wsr_word_format.sv
module wsr_word_format #(
    parameter int          DATA_W     = 8,
    parameter int          POLL_BIT   = 7,
    parameter int          TOGGLE_BIT = 6,
    parameter logic [DATA_W-1:0] FILL = '0
) (
    input  logic              rd,
    input  logic              busy,
    input  logic              tog,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] word,
    output logic              en
);
    logic [DATA_W-1:0] status;

    always_comb begin
        status             = FILL;
        status[POLL_BIT]   = ~last_byte[POLL_BIT];
        status[TOGGLE_BIT] = tog;
        en                 = rd;
        if (!rd)
            word = '0;
        else if (busy)
            word = status;
        else
            word = array_data;
    end
endmodule

// File: rtl/wr_status_responder.sv
module wr_status_responder #(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    import wsr_pkg::*;

    localparam logic [DATA_W-1:0] FILL_WORD = '0;

    ctl_t              ctl_d, ctl_q;
    logic [DATA_W-1:0] dout_d, dout_q;

    logic              rd_w, rd_start_w, tog_w, en_w;
    logic [DATA_W-1:0] word_w;

    wsr_strobe_decode i_strobe (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .rd_prev  (ctl_q.rd),
        .rd       (rd_w),
        .rd_start (rd_start_w)
    );

    wsr_toggle_next i_toggle (
        .tog_q     (ctl_q.tog),
        .busy      (busy),
        .busy_prev (ctl_q.busy),
        .rd_start  (rd_start_w),
        .tog_next  (tog_w)
    );

    wsr_word_format #(
        .DATA_W     (DATA_W),
        .POLL_BIT   (POLL_BIT),
        .TOGGLE_BIT (TOGGLE_BIT),
        .FILL       (FILL_WORD)
    ) i_format (
        .rd         (rd_w),
        .busy       (busy),
        .tog        (tog_w),
        .last_byte  (last_byte),
        .array_data (array_data),
        .word       (word_w),
        .en         (en_w)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rd   = rd_w;
        ctl_d.busy = busy;
        ctl_d.tog  = tog_w;
        ctl_d.en   = en_w;
        dout_d     = word_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CTL_RESET;
            dout_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            dout_q <= dout_d;
        end
    end

    assign dout    = dout_q;
    assign dout_en = ctl_q.en;

endmodule

// File: rtl/wsr_chk.sv
module wsr_chk #(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              busy,
    input logic [DATA_W-1:0] last_byte,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);
    logic [1:0] age_q;
    logic       rd_c;
    logic       poll_c;

    assign rd_c   = !ce_n && !oe_n && we_n;
    assign poll_c = rd_c && busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age_q <= 2'd0;
        else if (age_q != 2'd2)
            age_q <= age_q + 2'd1;
    end

    assert_en_tracks_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) |-> (dout_en == $past(rd_c)));

    assert_quiet_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    assert_poll_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q != 2'd0) && $past(poll_c)) |-> (dout[POLL_BIT] == ~$past(last_byte[POLL_BIT])));

    assert_held_read_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 2'd2) && $past(poll_c) && $past(poll_c, 2))
            |-> (dout[TOGGLE_BIT] == $past(dout[TOGGLE_BIT])));

    assert_fill_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q != 2'd0) && $past(poll_c))
            |-> ((dout & ~((DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT))) == '0));

    assert_true_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q != 2'd0) && $past(rd_c && !busy)) |-> (dout == $past(array_data)));

endmodule

bind wr_status_responder wsr_chk #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
) i_wsr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .busy       (busy),
    .last_byte  (last_byte),
    .array_data (array_data),
    .dout       (dout),
    .dout_en    (dout_en)
);

// File: tb/test_wr_status_responder.sv
`timescale 1ns/1ps
module test_wr_status_responder;
    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
    logic [7:0] last_byte = 8'h00, array_data = 8'h00;
    logic [7:0] dout;
    logic       dout_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Requirement-level model state
    logic m_rdp = 1'b0, m_busyp = 1'b0, m_tog = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    wr_status_responder i_wr_status_responder (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .busy(busy), .last_byte(last_byte), .array_data(array_data),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input string tag, input logic [7:0] act_d, input logic act_e,
                         input logic [7:0] exp_d, input logic exp_e);
        checks++;
        if (act_d !== exp_d || act_e !== exp_e) begin
            errors++;
            $display("FAIL %s: dout=%02h en=%0b expected dout=%02h en=%0b",
                     tag, act_d, act_e, exp_d, exp_e);
        end
    endtask

    // Apply inputs just after a falling edge, let one rising edge capture them,
    // then compare at the following falling edge.
    task automatic cyc(input logic c, input logic o, input logic w, input logic b,
                       input logic [7:0] lb, input logic [7:0] ad, input string tag);
        logic       rd, base;
        logic [7:0] exp_d;
        ce_n = c; oe_n = o; we_n = w; busy = b; last_byte = lb; array_data = ad;
        rd    = !c && !o && w;
        base  = (b && !m_busyp) ? 1'b0 : m_tog;
        m_tog = (b && rd && !m_rdp) ? ~base : base;
        if (!rd)    exp_d = 8'h00;
        else if (b) exp_d = {~lb[7], m_tog, 6'b000000};
        else        exp_d = ad;
        m_rdp = rd; m_busyp = b;
        @(posedge clk);
        @(negedge clk);
        check(tag, dout, dout_en, exp_d, rd);
    endtask

    task automatic idle(input logic b);
        cyc(1'b1, 1'b1, 1'b1, b, 8'h00, 8'h00, "R3 idle");
    endtask

    task automatic read(input logic b, input logic [7:0] lb, input logic [7:0] ad, input string tag);
        cyc(1'b0, 1'b0, 1'b1, b, lb, ad, tag);
    endtask

    initial begin : watchdog
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 in reset", dout, dout_en, 8'h00, 1'b0);
        rst_n = 1'b1;
        idle(1'b0);
        check("R1 after release", dout, dout_en, 8'h00, 1'b0);

        // R2/R3/R4/R7: every strobe combination, busy low and high
        for (int b = 0; b < 2; b++) begin
            for (int p = 0; p < 8; p++) begin
                idle(b[0]);
                cyc(p[2], p[1], p[0], b[0], 8'hA5 + 8'(p), 8'h3C ^ 8'(p), "R2 strobe sweep");
            end
        end

        // R4/R6/R9: every last_byte value, array data inverted
        idle(1'b0);
        for (int i = 0; i < 256; i++) begin
            idle(1'b1);
            read(1'b1, 8'(i), ~8'(i), "R4 R6 R9 poll sweep");
        end

        // R5: one access held for several cycles keeps bit 6 constant
        idle(1'b1);
        for (int k = 0; k < 5; k++) read(1'b1, 8'h81, 8'h55, "R5 held read");
        // R5: successive accesses alternate
        for (int k = 0; k < 6; k++) begin
            idle(1'b1);
            read(1'b1, 8'h81, 8'h55, "R5 alternate");
        end

        // R7: cycle done, true data on all bits, bit 6 frozen
        for (int k = 0; k < 8; k++) begin
            idle(1'b0);
            read(1'b0, 8'h81, 8'(k * 37 + 5), "R7 true data");
        end

        // R8: end a cycle with odd number of accesses, then start a new one
        idle(1'b1);
        read(1'b1, 8'h00, 8'h00, "R8 first read");
        idle(1'b1);
        read(1'b1, 8'h00, 8'h00, "R8 second read");
        idle(1'b1);
        read(1'b1, 8'h00, 8'h00, "R8 third read");
        idle(1'b0);
        idle(1'b1);
        read(1'b1, 8'h00, 8'hFF, "R8 new cycle");
        checks++;
        if (dout[6] !== 1'b1) begin
            errors++;
            $display("FAIL R8: bit6=%0b expected 1", dout[6]);
        end
        // R8: busy rising during a held read restarts the sequence
        idle(1'b0);
        read(1'b0, 8'h00, 8'h12, "R8 read before busy");
        read(1'b1, 8'h00, 8'h12, "R8 busy rises under held read");
        idle(1'b1);
        read(1'b1, 8'h00, 8'h12, "R8 next access");

        // R2: write strobe low with both enables low never drives the pads
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h7F, 8'h7F, "R2 write strobe");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h7F, 8'h7F, "R2 write strobe idle");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule